// File: doc/BRIEF.md
# Gated DC-Reject Washout Filter

This block strips the standing offset from a stream of signed converter samples. Each sample arrives with a one-cycle valid strobe. The block subtracts a running estimate of the offset, saturates the difference to the output width and registers it. The output carries its own strobe, which follows the input strobe one cycle later. The estimate moves a fraction 2^-CUT of each output toward the input, so the response is a first-order high-pass with its pole at (N-1)/N, where N = 2^CUT, plus one extra sample of delay. The estimate is kept with CUT fractional bits, so small corrections are not lost.

A control input `adapt_en` chooses between tracking and holding. While it is low, the estimate stays frozen and samples still pass through with the frozen offset removed. A synchronous reset clears the estimate. A sticky flag reports when valid strobes arrive on back-to-back cycles, which is closer spacing than the sample stream is meant to use.

Top module: `dc_washout`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_vld`, `out_smp` and `spacing_err` are 0. The offset estimate is zero, so the first valid sample after reset comes out unchanged.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock.
- R3: On a valid sample x, the next cycle's `out_smp` is x minus floor(acc / 2^CUT), where acc is the estimate in units of 2^-CUT. Without a valid sample, `out_smp` holds its value.
- R4: With `adapt_en` high, each valid sample adds its unsaturated difference to acc. This makes the estimate leak toward the input with factor (N-1)/N.
- R5: With `adapt_en` low, acc does not change, and each valid x produces x minus the frozen offset.
- R6: A difference above 2^(OUT_W-1)-1 gives that maximum. A difference below -2^(OUT_W-1) gives that minimum.
- R7: `spacing_err` is set when `in_vld` is high on two consecutive cycles. It stays set until `rst`.
- R8: A constant input with `adapt_en` high drives the output to within 1 LSB of zero.
- R9: With CUT = 4, a sinusoid at 7/33 of the sample rate comes out with an amplitude about 1.031 times the input amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz target |
| rst | input | 1 | Synchronous active-high reset; clears the estimate and the flag |
| adapt_en | input | 1 | 1: estimate tracks the input, 0: estimate frozen |
| in_smp | input | IN_W | Signed input sample |
| in_vld | input | 1 | Input sample strobe |
| out_smp | output | OUT_W | Signed filtered sample, registered |
| out_vld | output | 1 | Output strobe, one cycle after `in_vld` |
| spacing_err | output | 1 | Sticky flag for back-to-back input strobes |

## Verification
The bench uses the defaults: IN_W = 16, OUT_W = 16 and CUT = 4. With these values the internal difference spans 19 bits, so an estimate parked near one rail and a full-scale sample of the opposite sign push the output into both saturation limits. CUT = 4 also places the 7/33 test tone where the expected gain of about 1.031 is large enough to tell apart from unity. The settling from a constant input takes a few hundred samples, which keeps the run short.

// File: rtl/washout_pkg.sv
package washout_pkg;
  typedef enum logic {
    EST_HOLD  = 1'b0,
    EST_TRACK = 1'b1
  } est_mode_e;
endpackage

// File: rtl/wo_dc_tracker.sv
module wo_dc_tracker
  import washout_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int CUT  = 4,
  parameter int DC_W   = IN_W + 2,
  parameter int DIFF_W = IN_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  est_mode_e                mode,
  input  logic signed [DIFF_W-1:0] diff,
  output logic signed [DC_W-1:0]   dc_int
);
  localparam int ACC_W = DC_W + CUT;

  logic signed [ACC_W-1:0] acc;
  logic                    upd;

  assign upd = smp_vld && (mode == EST_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (upd) begin
      acc <= acc + ACC_W'(diff);
    end
  end

  // integer part of the estimate, arithmetic floor of acc / 2^CUT
  assign dc_int = acc[ACC_W-1:CUT];

  AST_FROZEN_EST: assert property (@(posedge clk) disable iff (rst)
    (mode == EST_HOLD) |=> $stable(acc)); // R5
  AST_IDLE_EST: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(acc)); // R4
endmodule

// File: rtl/wo_diff_sat.sv
module wo_diff_sat #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int DC_W   = IN_W + 2,
  parameter int DIFF_W = IN_W + 3
) (
  input  logic signed [IN_W-1:0]   x,
  input  logic signed [DC_W-1:0]   dc_int,
  output logic signed [DIFF_W-1:0] diff,
  output logic signed [OUT_W-1:0]  y_sat
);
  assign diff = DIFF_W'(x) - DIFF_W'(dc_int);

  generate
    if (OUT_W < DIFF_W) begin : g_clamp
      localparam logic signed [OUT_W-1:0] Y_MAX = {1'b0, {(OUT_W-1){1'b1}}};
      localparam logic signed [OUT_W-1:0] Y_MIN = {1'b1, {(OUT_W-1){1'b0}}};
      logic fits;
      // in range when every bit above the output sign bit copies the sign
      assign fits = (diff[DIFF_W-1:OUT_W-1] == '0) || (diff[DIFF_W-1:OUT_W-1] == '1);
      always_comb begin
        if (fits)              y_sat = diff[OUT_W-1:0];
        else if (diff[DIFF_W-1]) y_sat = Y_MIN;
        else                   y_sat = Y_MAX;
      end
    end else begin : g_extend
      assign y_sat = OUT_W'(diff);
    end
  endgenerate
endmodule

// File: rtl/wo_gate_mon.sv
module wo_gate_mon (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  output logic out_vld,
  output logic spacing_err
);
  logic prev_vld;

  always_ff @(posedge clk) begin
    prev_vld <= in_vld;
    if (rst) begin
      out_vld     <= 1'b0;
      spacing_err <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld && prev_vld) spacing_err <= 1'b1;
    end
  end

  AST_GATE_ON: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R2
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    spacing_err |=> spacing_err); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (in_vld && $past(in_vld)) |=> spacing_err); // R7
endmodule

// File: rtl/dc_washout.sv
module dc_washout
  import washout_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int CUT   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adapt_en,
  input  logic signed [IN_W-1:0]  in_smp,
  input  logic                    in_vld,
  output logic signed [OUT_W-1:0] out_smp,
  output logic                    out_vld,
  output logic                    spacing_err
);
  localparam int DC_W   = IN_W + 2;
  localparam int DIFF_W = IN_W + 3;
  localparam longint OUT_MAX = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint OUT_MIN = -(64'sd1 <<< (OUT_W - 1));

  logic signed [DC_W-1:0]   dc_int;
  logic signed [DIFF_W-1:0] diff;
  logic signed [OUT_W-1:0]  y_sat;
  est_mode_e                mode;

  assign mode = adapt_en ? EST_TRACK : EST_HOLD;

  wo_diff_sat #(
    .IN_W(IN_W), .OUT_W(OUT_W), .DC_W(DC_W), .DIFF_W(DIFF_W)
  ) u_diff (
    .x(in_smp), .dc_int(dc_int), .diff(diff), .y_sat(y_sat)
  );

  wo_dc_tracker #(
    .IN_W(IN_W), .CUT(CUT), .DC_W(DC_W), .DIFF_W(DIFF_W)
  ) u_est (
    .clk(clk), .rst(rst), .smp_vld(in_vld), .mode(mode),
    .diff(diff), .dc_int(dc_int)
  );

  wo_gate_mon u_gate (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .out_vld(out_vld), .spacing_err(spacing_err)
  );

  // output register: the extra sample of delay
  always_ff @(posedge clk) begin
    if (rst)         out_smp <= '0;
    else if (in_vld) out_smp <= y_sat;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_smp)); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (longint'(diff) > OUT_MAX)) |=> (longint'(out_smp) == OUT_MAX)); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (longint'(diff) < OUT_MIN)) |=> (longint'(out_smp) == OUT_MIN)); // R6
endmodule

// File: tb/dc_washout_test.sv
module dc_washout_test;
  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int CUT   = 4;
  localparam longint OMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (OUT_W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adapt_en = 1'b1;
  logic signed [IN_W-1:0] in_smp = '0;
  logic in_vld = 1'b0;
  logic signed [OUT_W-1:0] out_smp;
  logic out_vld;
  logic spacing_err;

  int checks = 0;
  int fails = 0;

  // reference state
  longint m_acc = 0;
  longint m_out = 0;
  bit m_vld = 0, m_err = 0, m_prev = 0;

  always #4 clk = ~clk;

  dc_washout #(.IN_W(IN_W), .OUT_W(OUT_W), .CUT(CUT)) uut (
    .clk(clk), .rst(rst), .adapt_en(adapt_en), .in_smp(in_smp), .in_vld(in_vld),
    .out_smp(out_smp), .out_vld(out_vld), .spacing_err(spacing_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint clampv(input longint d);
    if (d > OMAX) return OMAX;
    if (d < OMIN) return OMIN;
    return d;
  endfunction

  // called at a falling edge; applies one cycle of input and compares after the next edge
  task automatic tick(input bit v, input int x);
    longint d;
    in_vld = v;
    in_smp = IN_W'(x);
    if (v) begin
      d = longint'(x) - (m_acc >>> CUT);
      m_out = clampv(d);
      if (adapt_en) m_acc += d;
    end
    m_err = m_err | (v & m_prev);
    m_prev = v;
    m_vld = v;
    @(negedge clk);
    chk(out_vld == m_vld, "R2 out_vld", longint'(out_vld), longint'(m_vld));
    chk(longint'(out_smp) == m_out, "R3 out_smp", longint'(out_smp), m_out);
    chk(spacing_err == m_err, "R7 spacing_err", longint'(spacing_err), longint'(m_err));
  endtask

  task automatic do_reset();
    in_vld = 0;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk(out_vld == 0 && out_smp == 0 && spacing_err == 0, "R1 in reset",
        longint'(out_smp), 0);
    rst = 0;
    m_acc = 0; m_out = 0; m_vld = 0; m_err = 0; m_prev = 0;
  endtask

  task automatic sample(input int x);
    tick(1, x);
    tick(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint inmax, outmax;
    real ratio;
    int xv;
    @(negedge clk);
    do_reset();
    tick(0, 0);
    chk(out_vld == 0 && out_smp == 0 && spacing_err == 0, "R1 after reset",
        longint'(out_smp), 0);
    // R1: zero estimate, first sample passes unchanged
    tick(1, 1234);
    chk(out_smp == 1234, "R1 first sample", longint'(out_smp), 1234);
    tick(0, 0);
    chk(out_smp == 1234, "R3 hold without strobe", longint'(out_smp), 1234);

    // R4 R8: constant input settles to zero
    do_reset();
    adapt_en = 1;
    sample(1000);
    chk(out_smp == 1000, "R4 first step", longint'(out_smp), 1000);
    sample(1000);
    chk(out_smp == 938, "R4 second step leak", longint'(out_smp), 938);
    for (int k = 0; k < 300; k++) sample(1000);
    chk(out_smp >= -1 && out_smp <= 1, "R8 decay to zero", longint'(out_smp), 0);

    // R5: freeze, offset stays at 1000
    adapt_en = 0;
    for (int k = 0; k < 20; k++) begin
      sample(1500);
      chk(out_smp == 500, "R5 frozen offset", longint'(out_smp), 500);
    end
    sample(-200);
    chk(out_smp == -1200, "R5 frozen offset neg", longint'(out_smp), -1200);

    // R6: park estimate high, then full-scale negative
    do_reset();
    adapt_en = 1;
    for (int k = 0; k < 300; k++) sample(30000);
    adapt_en = 0;
    sample(-32768);
    chk(longint'(out_smp) == OMIN, "R6 low clamp", longint'(out_smp), OMIN);
    do_reset();
    adapt_en = 1;
    for (int k = 0; k < 300; k++) sample(-30000);
    adapt_en = 0;
    sample(32767);
    chk(longint'(out_smp) == OMAX, "R6 high clamp", longint'(out_smp), OMAX);

    // R9: gain at 7/33 of the sample rate
    do_reset();
    adapt_en = 1;
    inmax = 0; outmax = 0;
    for (int k = 0; k < 660; k++) begin
      xv = $rtoi($floor(8000.0 * $sin(2.0 * 3.14159265358979 * 7.0 * k / 33.0) + 0.5));
      sample(xv);
      if (k >= 495) begin
        if ((xv < 0 ? -xv : xv) > inmax) inmax = (xv < 0 ? -xv : xv);
        if ((out_smp < 0 ? -longint'(out_smp) : longint'(out_smp)) > outmax)
          outmax = (out_smp < 0 ? -longint'(out_smp) : longint'(out_smp));
      end
    end
    ratio = real'(outmax) / real'(inmax);
    chk(ratio > 1.02 && ratio < 1.045, "R9 gain near 1.031", outmax, inmax);

    // R7: back-to-back strobes set a sticky flag, reset clears it
    chk(spacing_err == 0, "R7 clear with spaced strobes", longint'(spacing_err), 0);
    tick(1, 10);
    tick(1, 20);
    chk(spacing_err == 1, "R7 set", longint'(spacing_err), 1);
    for (int k = 0; k < 5; k++) tick(0, 0);
    chk(spacing_err == 1, "R7 sticky", longint'(spacing_err), 1);
    do_reset();
    tick(0, 0);
    chk(spacing_err == 0, "R1 R7 cleared by reset", longint'(spacing_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule